// File: doc/BRIEF.md
# Three-Wire Serial Bus Master

This block is a host-side controller for a synchronous serial link made of three wires: a chip-enable, a serial clock and a single data line that both ends drive in turn. A client inside the chip asks for one byte to be read or written at a 6-bit target address. The block then runs the whole bus sequence on its own. For a read it returns the byte it received, together with a one-cycle done pulse. A write ends with the same pulse.

Before each transfer the block holds the bus quiet: chip-enable, clock and data all low. It then raises chip-enable and shifts out a command byte. A write follows the command with the data byte. A read releases the data line and clocks in the target's reply. All bytes travel least significant bit first. The serial clock is made from the system clock. Each of its two phases lasts a number of system clocks set by an input.

Top module: `tw_serial_master`

## Requirements
- R1: After reset, chipEn, serClk, serDout and done are 0, busy is 0, serDoutEn is 1 and rdData is 0.
- R2: The command byte has bit 7 = 1, bits 6:1 = the request address, and bit 0 = 1 for a read or 0 for a write. It goes out first on serDout, bit 0 first.
- R3: A write shifts 8 command bits and then the 8 data bits, bit 0 first. Each bit is placed on serDout at the start of its clock-low phase and held through the following high phase. Chip-enable then drops.
- R4: On a read, serDoutEn goes to 0 for the 8 bits after the command and serDout is 0 there. serDin is sampled on the last system clock of each clock-low phase. The first bit sampled lands in rdData bit 0. rdData shows the byte from the done cycle onward and is left unchanged by writes.
- R5: Each serial clock low phase and each high phase lasts H = max(halfPeriod, 1) system clocks. H is taken at acceptance; changing halfPeriod during a transfer has no effect on that transfer.
- R6: Count the first cycle after the accepting edge as cycle 0. For cycles 0 to 2H-1, chipEn, serClk and serDout are 0 and serDoutEn is 1. chipEn is 1 from cycle 2H through cycle 34H-1.
- R7: A request is accepted on a rising edge where reqValid is 1 and busy is 0. busy is 1 from cycle 0 through the done cycle. Requests presented while busy are ignored.
- R8: done is 1 for exactly one cycle, cycle 34H, with chipEn low.
- R9: serClk is high only while chipEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Target address |
| reqData | input | 8 | Byte to write |
| halfPeriod | input | 8 | System clocks per serial clock phase (0 acts as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdData | output | 8 | Last byte read |
| chipEn | output | 1 | Link chip-enable |
| serClk | output | 1 | Serial clock |
| serDout | output | 1 | Data line output value |
| serDoutEn | output | 1 | Data line output enable |
| serDin | input | 1 | Data line input value |

## Verification
Every result is due at a fixed cycle after the accepting edge. Cycle 0 is the first cycle after that edge. busy rises in cycle 0. chipEn rises in cycle 2H. Bit b occupies cycles 2H+2Hb to 2H+2Hb+2H-1, with its high phase in the second half. done and the new rdData appear in cycle 34H. The bench keeps a behavioural timeline counter that starts at the accepting edge. It derives every expected port value from that counter and compares all outputs at each falling edge, half a cycle clear of the edge that updates them. The bench drives the reply on serDin from the same counter, so a read is checked against a sample taken at the last low cycle.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIET,
    ST_LOW,
    ST_HIGH,
    ST_DONE
  } twsmState_e;

  typedef struct packed {
    logic load;      // capture request into shift register
    logic shiftTx;   // advance to next outgoing bit
    logic sampleRx;  // take serDin into receive register
    logic commit;    // publish received byte
  } twsmStrobe_t;
endpackage

// File: rtl/twsm_ctrl.sv
module twsm_ctrl
  import twsm_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [DIV_W-1:0] halfPeriod,
  output twsmStrobe_t      strobe,
  output logic             busy,
  output logic             done,
  output logic             chipEn,
  output logic             serClk,
  output logic             serDoutEn,
  output logic             driveBit
);
  localparam int TOTAL = CMD_W + DATA_W;
  localparam int BIT_W = $clog2(TOTAL);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL - 1);
  localparam logic [BIT_W-1:0] FIRST_RX = BIT_W'(CMD_W);

  twsmState_e       state;
  logic [CNT_W-1:0] phaseCnt;
  logic [DIV_W-1:0] halfReg;
  logic [BIT_W-1:0] bitIdx;
  logic             isRead;

  logic [CNT_W-1:0] halfExt;
  logic             phaseEnd;
  logic             quietEnd;
  logic             inBits;
  logic             rxPhase;
  logic             accept;

  assign halfExt  = {1'b0, halfReg};
  assign phaseEnd = (phaseCnt == halfExt - CNT_W'(1));
  assign quietEnd = (phaseCnt == (halfExt << 1) - CNT_W'(1));
  assign inBits   = (state == ST_LOW) || (state == ST_HIGH);
  assign rxPhase  = isRead && (bitIdx >= FIRST_RX);
  assign accept   = (state == ST_IDLE) && reqValid;

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.shiftTx  = (state == ST_HIGH) && phaseEnd;
    strobe.sampleRx = (state == ST_LOW) && phaseEnd && rxPhase;
    strobe.commit   = (state == ST_HIGH) && phaseEnd && isRead && (bitIdx == LAST_BIT);
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign chipEn    = inBits;
  assign serClk    = (state == ST_HIGH);
  assign serDoutEn = !(inBits && rxPhase);
  assign driveBit  = inBits && !rxPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      halfReg  <= DIV_W'(1);
      bitIdx   <= '0;
      isRead   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_QUIET;
            phaseCnt <= '0;
            halfReg  <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
            isRead   <= !reqWrite;
            bitIdx   <= '0;
          end
        end
        ST_QUIET: begin
          if (quietEnd) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            state    <= ST_HIGH;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (bitIdx == LAST_BIT) begin
              state <= ST_DONE;
            end else begin
              state  <= ST_LOW;
              bitIdx <= bitIdx + BIT_W'(1);
            end
          end else begin
            phaseCnt <= phaseCnt + CNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twsm_dpath.sv
module twsm_dpath
  import twsm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsmStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              driveBit,
  input  logic              serDin,
  output logic              serDout,
  output logic [DATA_W-1:0] rdData
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int TOTAL = CMD_W + DATA_W;

  logic [TOTAL-1:0]  txShift;
  logic [DATA_W-1:0] rxShift;
  logic [CMD_W-1:0]  cmdByte;

  // marker bit on top, address in the middle, direction flag at bit 0
  assign cmdByte = {1'b1, reqAddr, !reqWrite};
  assign serDout = driveBit && txShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= {reqData, cmdByte};
        rxShift <= '0;
      end else if (strobe.shiftTx) begin
        txShift <= txShift >> 1;
      end
      if (strobe.sampleRx) rxShift <= {serDin, rxShift[DATA_W-1:1]};
      if (strobe.commit)   rdData  <= rxShift;
    end
  end
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import twsm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DIV_W-1:0]  halfPeriod,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              chipEn,
  output logic              serClk,
  output logic              serDout,
  output logic              serDoutEn,
  input  logic              serDin
);
  localparam int CMD_W = ADDR_W + 2;

  twsmStrobe_t strobe;
  logic        driveBit;

  twsm_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .halfPeriod(halfPeriod), .strobe(strobe), .busy(busy), .done(done),
    .chipEn(chipEn), .serClk(serClk), .serDoutEn(serDoutEn), .driveBit(driveBit)
  );

  twsm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .driveBit(driveBit),
    .serDin(serDin), .serDout(serDout), .rdData(rdData)
  );
endmodule

// File: rtl/twsm_check.sv
module twsm_check (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic chipEn,
  input logic serClk,
  input logic serDout,
  input logic serDoutEn
);
  AST_SCLK_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> chipEn);                                  // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                     // R8
  AST_DONE_CE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!chipEn && busy));                         // R8
  AST_CE_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipEn) |-> !serClk);                          // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);                           // R7
  AST_CE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    chipEn |-> busy);                                    // R7
  AST_RELEASE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !serDoutEn |-> (chipEn && !serDout));                // R4
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serDout));     // R3
endmodule

bind tw_serial_master twsm_check u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .chipEn(chipEn),
  .serClk(serClk), .serDout(serDout), .serDoutEn(serDoutEn)
);

// File: tb/sim_tw_serial_master.sv
`timescale 1ns/1ps
module sim_tw_serial_master;
  logic       clk = 0;
  logic       rstN = 0;
  logic       reqValid = 0, reqWrite = 0;
  logic [5:0] reqAddr = 0;
  logic [7:0] reqData = 0, halfPeriod = 8'd1;
  logic       serDin = 0;
  logic       busy, done, chipEn, serClk, serDout, serDoutEn;
  logic [7:0] rdData;

  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0;

  // reference timeline state
  bit         mActive = 0, mRead = 0;
  int         mT = 0, mH = 1;
  logic [15:0] mWord = 0;
  logic [7:0]  mExpRd = 0, slaveByte = 8'h00;

  always #10 clk = ~clk;

  tw_serial_master u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .halfPeriod(halfPeriod),
    .busy(busy), .done(done), .rdData(rdData), .chipEn(chipEn),
    .serClk(serClk), .serDout(serDout), .serDoutEn(serDoutEn), .serDin(serDin)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0d", req, what, act, exp, mT);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mT = 0; mExpRd = 0;
    end else if (!mActive) begin
      if (reqValid) begin
        mActive = 1; mT = 0; mRead = !reqWrite;
        mH = (halfPeriod == 0) ? 1 : int'(halfPeriod);
        mWord = {reqData, 1'b1, reqAddr, !reqWrite};
      end
    end else if (mT == 34 * mH) begin
      mActive = 0;
    end else begin
      mT++;
      if (mT == 34 * mH && mRead) mExpRd = slaveByte;
    end
  end

  always @(negedge clk) begin
    int  b, u;
    bit  eCe, eClk, eDo, eEn, eDone, hi;
    eCe = 0; eClk = 0; eDo = 0; eEn = 1; eDone = 0; b = -1;
    if (mActive && mT >= 2 * mH && mT < 34 * mH) begin
      u = mT - 2 * mH;
      b = u / (2 * mH);
      hi = (u % (2 * mH)) >= mH;
      eCe = 1; eClk = hi;
      eEn = !(mRead && b >= 8);
      eDo = eEn ? mWord[b] : 1'b0;
    end else if (mActive && mT == 34 * mH) begin
      eDone = 1;
    end
    serDin = (b >= 8 && mRead) ? slaveByte[b - 8] : 1'b0;
    if (rstN && !finished) begin
      check("R7", "busy", busy, mActive);
      check("R6", "chipEn", chipEn, eCe);
      check(eCe ? "R5" : "R9", "serClk", serClk, eClk);
      check("R4", "serDoutEn", serDoutEn, eEn);
      check((b >= 0 && b < 8) ? "R2" : "R3", "serDout", serDout, eDo);
      check("R8", "done", done, eDone);
      check("R4", "rdData", rdData, mExpRd);
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (mActive) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [5:0] a, input logic [7:0] d, input logic [7:0] hp);
    waitIdle();
    reqWrite = wr; reqAddr = a; reqData = d; halfPeriod = hp;
    reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values while reset held
    check("R1", "chipEn", chipEn, 0);
    check("R1", "serClk", serClk, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "serDoutEn", serDoutEn, 1);
    check("R1", "rdData", rdData, 0);
    rstN = 1;
    issue(1, 6'h20, 8'h42, 8'd1);                 // R3 write, fastest clock
    slaveByte = 8'h42; issue(0, 6'h20, 8'h00, 8'd2); // R4 read back
    slaveByte = 8'hA5; issue(0, 6'h3F, 8'hFF, 8'd0); // R5 zero acts as one
    issue(1, 6'h15, 8'h5A, 8'd3);                 // R2 address pattern
    // R7 requests while busy ignored, R5 halfPeriod change ignored
    repeat (6) @(negedge clk);
    reqWrite = 0; reqAddr = 6'h01; reqData = 8'h11; halfPeriod = 8'd7; reqValid = 1;
    @(negedge clk); reqValid = 0;
    // R6 back to back with reqValid held high
    waitIdle();
    slaveByte = 8'h3C;
    reqWrite = 0; reqAddr = 6'h07; halfPeriod = 8'd2; reqValid = 1;
    repeat (3 * 34 * 2 + 20) @(negedge clk);
    reqValid = 0;
    waitIdle();
    issue(1, 6'h00, 8'h80, 8'd4);                 // R4 rdData unchanged by write
    waitIdle();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule